// File: doc/BRIEF.md
# Bypassable System Clock Divider Chain

This block turns a fast reference clock into two enable pulse trains for the logic of a chip. One of two source tick streams is picked: the phase-locked loop ticks or the crystal ticks. The system stage divides the picked stream by a power of two and issues a one-cycle system enable. The system stage can also be bypassed, which gives divide by 1. The bus stage counts those system enables and produces the enable for the external bus clock. The bus stage is placed after the system stage, so every later divider sees the divided rate. All outputs are enables on the reference clock, not real clock edges.

Configuration comes in through a single write strobe, `cfg_we`, and is held inside the block. After reset the block is set to crystal source, system divide by 1 and bus divide by 2. A new ratio does not act at once. Each stage keeps counting its current period and loads the new ratio only at that period's terminal count, so the output never shows a short period. While no external bus access is in progress (`bus_busy` low), bus enables are suppressed. The bus counter keeps running during that time, so it stays in phase.

Each divider stage is a small state machine with two states:
- `ST_PASS`: the ratio is 1, and every input tick is terminal.
- `ST_COUNT`: the ratio is 2 or more, and the stage counts ticks up to its limit.

The transitions are:
- `PASS->COUNT`: taken at a terminal tick when the new shift is non-zero.
- `COUNT->PASS`: taken at a terminal tick when the new shift is zero.
- `PASS->PASS` and `COUNT->COUNT`: taken at a terminal tick when the kind of ratio does not change.
- Hold: taken on any non-terminal tick or when no tick arrives.

Top module: `clkdiv_chain`

## Requirements
- R1: With `cfg_src_pll`=1 the system stage counts `pll_tick`, and with 0 it counts `xtal_tick`. Reset selects the crystal.
- R2: After reset the system enable has a period equal to one source tick (the stage is bypassed). The bus enable has a period of two system enables.
- R3: While `cfg_bypass`=1 the system ratio is 1, whatever `cfg_sysdiv` holds.
- R4: While `cfg_bypass`=0, `cfg_sysdiv` sets the system ratio: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16.
- R5: `cfg_ebdf` sets the bus ratio in system enables: 00 gives 1, 01 gives 2, 10 gives 2 and 11 gives 4.
- R6: The bus stage counts system enables, so the bus period in reference cycles is the system period times the bus ratio.
- R7: While `bus_busy`=0 no bus enable is produced, and system enables continue.
- R8: A ratio change takes effect only at the terminal count of the current ratio. The period in progress completes at the old ratio, then the new ratio follows.
- R9: Each enable is high for one reference cycle. It is registered in the cycle after the input tick that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | Phase-locked loop source tick |
| xtal_tick | input | 1 | Crystal source tick |
| cfg_we | input | 1 | Loads the configuration fields below |
| cfg_src_pll | input | 1 | Source select: 1 = PLL, 0 = crystal |
| cfg_bypass | input | 1 | 1 = system stage divides by 1 |
| cfg_sysdiv | input | 2 | System ratio code, used only when not bypassed |
| cfg_ebdf | input | 2 | Bus ratio code |
| bus_busy | input | 1 | External bus access in progress |
| sys_ce | output | 1 | System clock enable pulse |
| bus_ce | output | 1 | External bus clock enable pulse |

## Verification
The system stage is measured with each `cfg_sysdiv` code, both with and without bypass. This shows that bypass masks the field and that each code maps to its own ratio. Each bus code is measured over a fixed system ratio, and the ratio products are checked with both sources. The ticks of the two sources run at different rates, so a wrong select appears as a doubled or halved period. A ratio is also changed from 16 to 2 in the middle of a period. This shows the difference between a change at terminal count and an immediate reload, which would give a short period. An idle bus window shows that gating stops only the bus enables.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SYS_SHIFT_MAX = 4;
    localparam int BUS_SHIFT_MAX = 2;
    localparam int SYS_SW = $clog2(SYS_SHIFT_MAX + 1);
    localparam int BUS_SW = $clog2(BUS_SHIFT_MAX + 1);

    typedef enum logic [1:0] {
        EB_DIV1  = 2'b00,
        EB_DIV2  = 2'b01,
        EB_ALT2  = 2'b10,
        EB_DIV4  = 2'b11
    } ebdf_e;

    typedef enum logic {
        ST_PASS  = 1'b0,
        ST_COUNT = 1'b1
    } stage_st_e;
endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              src_pll_i,
    input  logic              bypass_i,
    input  logic [1:0]        sysdiv_i,
    input  logic [1:0]        ebdf_i,
    output logic              src_pll_o,
    output logic [SYS_SW-1:0] sys_shift_o,
    output logic [BUS_SW-1:0] bus_shift_o
);
    logic       src_q;
    logic       byp_q;
    logic [1:0] sdiv_q;
    ebdf_e      ebdf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            byp_q  <= 1'b1;
            sdiv_q <= 2'b00;
            ebdf_q <= EB_DIV2;
        end else if (we_i) begin
            src_q  <= src_pll_i;
            byp_q  <= bypass_i;
            sdiv_q <= sysdiv_i;
            ebdf_q <= ebdf_e'(ebdf_i);
        end
    end

    assign src_pll_o = src_q;

    always_comb begin
        if (byp_q) sys_shift_o = '0;
        else       sys_shift_o = SYS_SW'(sdiv_q) + SYS_SW'(1);
    end

    always_comb begin
        unique case (ebdf_q)
            EB_DIV1: bus_shift_o = BUS_SW'(0);
            EB_DIV2: bus_shift_o = BUS_SW'(1);
            EB_ALT2: bus_shift_o = BUS_SW'(1);
            EB_DIV4: bus_shift_o = BUS_SW'(2);
            default: bus_shift_o = BUS_SW'(1);
        endcase
    end

    // R3
    bypass_masks_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_q |-> (sys_shift_o == '0));
endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
    input  logic sel_pll_i,
    input  logic pll_tick_i,
    input  logic xtal_tick_i,
    output logic tick_o
);
    always_comb begin
        if (sel_pll_i) tick_o = pll_tick_i;
        else           tick_o = xtal_tick_i;
    end
endmodule

// File: rtl/clkdiv_pow2_stage.sv
module clkdiv_pow2_stage
    import clkdiv_pkg::*;
#(
    parameter int MAX_SHIFT = 4,
    parameter int RST_SHIFT = 0,
    localparam int SW = $clog2(MAX_SHIFT + 1),
    localparam int CW = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [SW-1:0] shift_i,
    input  logic          gate_i,
    output logic          ce_o
);
    stage_st_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim_q, lim_d;
    logic [CW-1:0] lim_nx;
    logic [CW-1:0] lim_rst;
    logic          term;

    always_comb begin
        for (int i = 0; i < CW; i++) begin
            lim_nx[i]  = (shift_i > SW'(i));
            lim_rst[i] = (RST_SHIFT > i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= (RST_SHIFT == 0) ? ST_PASS : ST_COUNT;
            cnt_q <= '0;
            lim_q <= lim_rst;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lim_d = lim_q;
        term  = 1'b0;
        unique case (st_q)
            ST_PASS: begin
                term = 1'b1;
            end
            ST_COUNT: begin
                term = (cnt_q == lim_q);
            end
            default: term = 1'b1;
        endcase
        if (tick_i) begin
            if (term) begin
                cnt_d = '0;
                lim_d = lim_nx;
                st_d  = (shift_i == '0) ? ST_PASS : ST_COUNT;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_o <= 1'b0;
        else        ce_o <= tick_i && term && gate_i;
    end

    // R9
    ce_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o |-> $past(tick_i));
    // R7
    ce_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o |-> $past(gate_i));
    // R8
    cnt_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT) |-> (cnt_q <= lim_q));
    // R8
    limit_moves_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lim_q) |-> $past(tick_i && term));
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_tick,
    input  logic       xtal_tick,
    input  logic       cfg_we,
    input  logic       cfg_src_pll,
    input  logic       cfg_bypass,
    input  logic [1:0] cfg_sysdiv,
    input  logic [1:0] cfg_ebdf,
    input  logic       bus_busy,
    output logic       sys_ce,
    output logic       bus_ce
);
    logic              src_pll;
    logic [SYS_SW-1:0] sys_shift;
    logic [BUS_SW-1:0] bus_shift;
    logic              src_tick;

    clkdiv_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we),
        .src_pll_i   (cfg_src_pll),
        .bypass_i    (cfg_bypass),
        .sysdiv_i    (cfg_sysdiv),
        .ebdf_i      (cfg_ebdf),
        .src_pll_o   (src_pll),
        .sys_shift_o (sys_shift),
        .bus_shift_o (bus_shift)
    );

    clkdiv_src_mux u_mux (
        .sel_pll_i   (src_pll),
        .pll_tick_i  (pll_tick),
        .xtal_tick_i (xtal_tick),
        .tick_o      (src_tick)
    );

    clkdiv_pow2_stage #(.MAX_SHIFT(SYS_SHIFT_MAX), .RST_SHIFT(0)) u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (src_tick),
        .shift_i (sys_shift),
        .gate_i  (1'b1),
        .ce_o    (sys_ce)
    );

    clkdiv_pow2_stage #(.MAX_SHIFT(BUS_SHIFT_MAX), .RST_SHIFT(1)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (sys_ce),
        .shift_i (bus_shift),
        .gate_i  (bus_busy),
        .ce_o    (bus_ce)
    );

    // R6
    bus_follows_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce |-> $past(sys_ce));
    // R9
    sys_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_ce && !$past(src_tick)) |-> 1'b0);
endmodule

// File: tb/clkdiv_chain_bench.sv
module clkdiv_chain_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_tick = 1'b0;
    logic xtal_tick = 1'b1;
    logic cfg_we = 1'b0;
    logic cfg_src_pll = 1'b0;
    logic cfg_bypass = 1'b1;
    logic [1:0] cfg_sysdiv = 2'b00;
    logic [1:0] cfg_ebdf = 2'b01;
    logic bus_busy = 1'b1;
    logic sys_ce, bus_ce;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    typedef struct {
        int    sys_p;
        int    bus_p;
        string tag;
    } exp_t;
    exp_t sb_q[$];
    event mon_done;

    clkdiv_chain u_clkdiv_chain (
        .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
        .cfg_we(cfg_we), .cfg_src_pll(cfg_src_pll), .cfg_bypass(cfg_bypass),
        .cfg_sysdiv(cfg_sysdiv), .cfg_ebdf(cfg_ebdf), .bus_busy(bus_busy),
        .sys_ce(sys_ce), .bus_ce(bus_ce)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            pll_tick = ~pll_tick;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_sys;
        do @(negedge clk); while (!sys_ce);
    endtask

    task automatic period_sys(output int p);
        wait_sys();
        p = 0;
        do begin @(negedge clk); p++; end while (!sys_ce);
    endtask

    task automatic period_bus(output int p);
        do @(negedge clk); while (!bus_ce);
        p = 0;
        do begin @(negedge clk); p++; end while (!bus_ce);
    endtask

    task automatic write_cfg(bit src, bit byp, logic [1:0] sd, logic [1:0] eb);
        @(negedge clk);
        cfg_src_pll = src; cfg_bypass = byp; cfg_sysdiv = sd; cfg_ebdf = eb;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_periods(int sp, int bp, string tag);
        exp_t e;
        repeat (150) @(negedge clk);
        e.sys_p = sp; e.bus_p = bp; e.tag = tag;
        sb_q.push_back(e);
        @(mon_done);
    endtask

    // monitor: pops expected items and measures the design's enables
    initial begin
        forever begin
            exp_t e;
            int p;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            period_sys(p);
            check({e.tag, " sys period"}, p, e.sys_p);
            if (e.bus_p > 0) begin
                period_bus(p);
                check({e.tag, " bus period"}, p, e.bus_p);
            end else begin
                int ns = 0;
                int nb = 0;
                repeat (64) begin
                    @(negedge clk);
                    if (sys_ce) ns++;
                    if (bus_ce) nb++;
                end
                check({e.tag, " gated bus pulses"}, nb, 0);
                check({e.tag, " sys pulses while gated"}, ns, 64 / e.sys_p);
            end
            ->mon_done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 sys_ce low in reset", int'(sys_ce), 0);
        check("R2 bus_ce low in reset", int'(bus_ce), 0);
        rst_n = 1'b1;
        // R1 R2: crystal ticks every cycle, bypass, bus /2
        expect_periods(1, 2, "R1 R2 reset defaults");
        // R3: bypass ignores sysdiv
        write_cfg(1'b0, 1'b1, 2'b11, 2'b01);
        expect_periods(1, 2, "R3 bypass masks 11");
        // R4: each system code
        write_cfg(1'b0, 1'b0, 2'b00, 2'b01);
        expect_periods(2, 4, "R4 code 00");
        write_cfg(1'b0, 1'b0, 2'b01, 2'b01);
        expect_periods(4, 8, "R4 code 01");
        write_cfg(1'b0, 1'b0, 2'b10, 2'b01);
        expect_periods(8, 16, "R4 code 10");
        write_cfg(1'b0, 1'b0, 2'b11, 2'b01);
        expect_periods(16, 32, "R4 code 11");
        // R5 R6: bus codes over system /4
        write_cfg(1'b0, 1'b0, 2'b01, 2'b00);
        expect_periods(4, 4, "R5 R6 ebdf 00");
        write_cfg(1'b0, 1'b0, 2'b01, 2'b10);
        expect_periods(4, 8, "R5 R6 ebdf 10");
        write_cfg(1'b0, 1'b0, 2'b01, 2'b11);
        expect_periods(4, 16, "R5 R6 ebdf 11");
        // R1: PLL ticks every other cycle
        write_cfg(1'b1, 1'b0, 2'b00, 2'b11);
        expect_periods(4, 16, "R1 pll source");
        write_cfg(1'b1, 1'b1, 2'b00, 2'b00);
        expect_periods(2, 2, "R1 pll bypass");
        // R7: idle bus gates bus enable only
        write_cfg(1'b0, 1'b0, 2'b00, 2'b00);
        @(negedge clk);
        bus_busy = 1'b0;
        expect_periods(2, 0, "R7 idle bus");
        bus_busy = 1'b1;
        expect_periods(2, 2, "R7 bus resumes");
        // R8: change 16 -> 2 mid period
        write_cfg(1'b0, 1'b0, 2'b11, 2'b00);
        repeat (100) @(negedge clk);
        begin
            int p = 0;
            wait_sys();
            repeat (3) begin @(negedge clk); p++; end
            cfg_sysdiv = 2'b00; cfg_bypass = 1'b0; cfg_src_pll = 1'b0; cfg_ebdf = 2'b00;
            cfg_we = 1'b1;
            @(negedge clk); p++;
            cfg_we = 1'b0;
            while (!sys_ce) begin @(negedge clk); p++; end
            check("R8 old ratio completes", p, 16);
            p = 0;
            do begin @(negedge clk); p++; end while (!sys_ce);
            check("R8 new ratio follows", p, 2);
        end
        // R9: enable lasts one cycle at divide by 2
        wait_sys();
        @(negedge clk);
        check("R9 single-cycle enable", int'(sys_ce), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule